// File: doc/BRIEF.md
# Special Register Move Execution Unit

This unit carries out the two instructions that copy a value between a general-purpose register (GPR) and a special-purpose register (SPR). In the "to special" direction it takes the source GPR value and stores all 64 bits in the chosen SPR. In the "from special" direction it returns the chosen SPR, ANDed with that register's readable-bit mask, as write-back data for the destination GPR. The unit holds the six SPRs it implements.

An issue stage presents one instruction per cycle. It gives a valid strobe, a direction bit, the raw 10-bit register field and, for the "to special" direction, the source GPR value. All results are registered and appear one cycle later, qualified by a result-valid output. The raw field stores the register number with its two 5-bit halves swapped. A small reserved range of numbers completes as a silent no-op. Every other number that is not implemented raises an interrupt flag and leaves all state untouched.

Top module: `sprmv_unit`

## Requirements
- R1: The register number is formed as num[4:0] = field[9:5] and num[9:5] = field[4:0], where field bit 0 is the least significant. A field that carries a valid number without the swap is decoded as the swapped number.
- R2: While reset is high, and on the cycles after it, the result outputs are low and all six SPRs read as zero.
- R3: A valid "to special" instruction (dir=1) aimed at an implemented number (1, 8, 9, 26, 27, 815) stores the full 64-bit source value in that SPR. Its result shows spr_wr=1, gpr_rd=1, gpr_wr=0 and intr=0.
- R4: A valid "from special" instruction (dir=0) aimed at an implemented number gives gpr_wr=1 with write data equal to the SPR value AND its mask, plus gpr_rd=0, spr_wr=0 and intr=0. Whenever gpr_wr is 0, the write data is zero.
- R5: Numbers 808 to 811 are reserved. In either direction they produce a result with every strobe and the interrupt flag low, and no SPR changes.
- R6: Any number that is neither implemented nor reserved gives intr=1 with gpr_rd, gpr_wr and spr_wr low, and no SPR changes.
- R7: A result appears exactly one cycle after each valid input, with res_valid=1. In a cycle where res_valid is 0, every strobe and the interrupt flag are 0.
- R8: An SPR write is visible to a "from special" instruction issued on the very next cycle.
- R9: Each SPR has its own 64-bit readable mask parameter. The mask shapes only the data read back, never the value that is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_to_spr | input | 1 | 1 = move to special, 0 = move from special |
| in_field | input | 10 | Raw register field with swapped halves |
| in_gpr_data | input | 64 | Source GPR value for move to special |
| res_valid | output | 1 | Result present this cycle |
| res_gpr_rd | output | 1 | Source GPR was read |
| res_gpr_wr | output | 1 | Destination GPR write enable |
| res_gpr_wdata | output | 64 | Destination GPR write data |
| res_spr_wr | output | 1 | An SPR was written |
| res_intr | output | 1 | Unimplemented register number |

## Verification
The bench targets the number decode at its edges: 807, 812, 816, 0 and 1023 sit just outside the implemented and reserved sets, and a field given without the half swap must trap. A decoder that skipped the swap, or that had an off-by-one on the reserved range, would answer with the wrong strobes or a missing interrupt. After every reserved or trapping access the bench reads back all six SPRs, so a write that leaked through would show up as a changed value. A write followed at once by a read of the same SPR, together with a non-trivial mask on the link register, exposes a read that returns stale data and masking applied on the write path.

// File: rtl/sprmv_pkg.sv
`timescale 1ns/1ps
package sprmv_pkg;
  localparam int SPR_NUM_W  = 10;
  localparam int SPR_COUNT  = 6;
  localparam int SPR_DATA_W = 64;

  // implemented numbers, entry i at [i*SPR_NUM_W +: SPR_NUM_W]:
  // 0 exception, 1 link, 2 count, 3 save0, 4 save1, 5 target
  localparam logic [SPR_COUNT*SPR_NUM_W-1:0] SPR_NUM_TABLE =
    {10'd815, 10'd27, 10'd26, 10'd9, 10'd8, 10'd1};

  localparam logic [SPR_NUM_W-1:0] RSV_FIRST = 10'd808;
  localparam logic [SPR_NUM_W-1:0] RSV_LAST  = 10'd811;

  typedef enum logic [1:0] {
    CLS_IMPL  = 2'd0,
    CLS_RSV   = 2'd1,
    CLS_UNDEF = 2'd2
  } spr_cls_e;
endpackage

// File: rtl/sprmv_decode.sv
`timescale 1ns/1ps
module sprmv_decode
  import sprmv_pkg::*;
#(
  parameter int NUM_W = SPR_NUM_W,
  parameter int N_SPR = SPR_COUNT,
  localparam int IDX_W = $clog2(N_SPR),
  localparam int HALF  = NUM_W / 2
) (
  input  logic [NUM_W-1:0] field,
  output spr_cls_e         cls,
  output logic [IDX_W-1:0] idx
);
  logic [NUM_W-1:0] num;
  logic [N_SPR-1:0] hit;

  // halves arrive swapped
  assign num = {field[HALF-1:0], field[NUM_W-1:HALF]};

  for (genvar g = 0; g < N_SPR; g++) begin : g_match
    assign hit[g] = (num == SPR_NUM_TABLE[g*NUM_W +: NUM_W]);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SPR; i++) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (|hit)                                  cls = CLS_IMPL;
    else if (num >= RSV_FIRST && num <= RSV_LAST) cls = CLS_RSV;
    else                                       cls = CLS_UNDEF;
  end
endmodule

// File: rtl/sprmv_regfile.sv
`timescale 1ns/1ps
module sprmv_regfile #(
  parameter int DATA_W = 64,
  parameter int N_SPR  = 6,
  localparam int IDX_W = $clog2(N_SPR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs_q [N_SPR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SPR; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_SPR; i++) begin
        if (wr_idx == IDX_W'(i)) regs_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = regs_q[rd_idx];

  // R3
  stored_value_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/sprmv_unit.sv
`timescale 1ns/1ps
module sprmv_unit
  import sprmv_pkg::*;
#(
  parameter int DATA_W = SPR_DATA_W,
  parameter int NUM_W  = SPR_NUM_W,
  parameter int N_SPR  = SPR_COUNT,
  parameter logic [N_SPR*DATA_W-1:0] RD_MASKS = '1,
  localparam int IDX_W = $clog2(N_SPR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_to_spr,
  input  logic [NUM_W-1:0]  in_field,
  input  logic [DATA_W-1:0] in_gpr_data,
  output logic              res_valid,
  output logic              res_gpr_rd,
  output logic              res_gpr_wr,
  output logic [DATA_W-1:0] res_gpr_wdata,
  output logic              res_spr_wr,
  output logic              res_intr
);
  spr_cls_e          cls;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] spr_val;
  logic [DATA_W-1:0] spr_mask;
  logic              is_impl, is_undef, do_write, do_read;

  sprmv_decode #(.NUM_W(NUM_W), .N_SPR(N_SPR)) dec_i (
    .field(in_field), .cls(cls), .idx(idx)
  );

  assign is_impl  = (cls == CLS_IMPL);
  assign is_undef = (cls == CLS_UNDEF);
  assign do_write = in_valid &  in_to_spr & is_impl;
  assign do_read  = in_valid & ~in_to_spr & is_impl;

  sprmv_regfile #(.DATA_W(DATA_W), .N_SPR(N_SPR)) rf_i (
    .clk(clk), .rst(rst),
    .wr_en(do_write), .wr_idx(idx), .wr_data(in_gpr_data),
    .rd_idx(idx), .rd_data(spr_val)
  );

  assign spr_mask = RD_MASKS[idx*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_gpr_rd    <= 1'b0;
      res_gpr_wr    <= 1'b0;
      res_gpr_wdata <= '0;
      res_spr_wr    <= 1'b0;
      res_intr      <= 1'b0;
    end else begin
      res_valid     <= in_valid;
      res_gpr_rd    <= do_write;
      res_gpr_wr    <= do_read;
      res_gpr_wdata <= do_read ? (spr_val & spr_mask) : '0;
      res_spr_wr    <= do_write;
      res_intr      <= in_valid & is_undef;
    end
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_gpr_rd || res_gpr_wr || res_spr_wr || res_intr));
  // R6
  trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    res_intr |-> !(res_gpr_rd || res_gpr_wr || res_spr_wr));
  // R5
  reserved_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls == CLS_RSV) |=> !(res_gpr_rd || res_gpr_wr || res_spr_wr || res_intr));
  // R4
  wdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !res_gpr_wr |-> res_gpr_wdata == '0);
  // R3
  direction_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_gpr_wr, res_spr_wr, res_intr}));
endmodule

// File: tb/sprmv_unit_tb_top.sv
`timescale 1ns/1ps
module sprmv_unit_tb_top;
  localparam logic [63:0] ONES     = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] LINK_MSK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [6*64-1:0] TB_MASKS = {ONES, ONES, ONES, ONES, LINK_MSK, ONES};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_to_spr = 1'b0;
  logic [9:0]  in_field = '0;
  logic [63:0] in_gpr_data = '0;
  logic res_valid, res_gpr_rd, res_gpr_wr, res_spr_wr, res_intr;
  logic [63:0] res_gpr_wdata;

  always #4 clk = ~clk;

  sprmv_unit #(.RD_MASKS(TB_MASKS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_to_spr(in_to_spr),
    .in_field(in_field), .in_gpr_data(in_gpr_data),
    .res_valid(res_valid), .res_gpr_rd(res_gpr_rd), .res_gpr_wr(res_gpr_wr),
    .res_gpr_wdata(res_gpr_wdata), .res_spr_wr(res_spr_wr), .res_intr(res_intr)
  );

  typedef struct {
    logic        rd, wr, sw, intr;
    logic [63:0] wdata;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model [6];
  int total = 0, bad = 0;
  int cycles = 0;
  bit done = 0;
  bit started = 0;
  int impl_nums [6] = '{1, 8, 9, 26, 27, 815};

  function automatic logic [63:0] mask_of(int i);
    return (i == 1) ? LINK_MSK : ONES;
  endfunction

  function automatic int idx_of(logic [9:0] num);
    for (int i = 0; i < 6; i++) if (num == 10'(impl_nums[i])) return i;
    return -1;
  endfunction

  function automatic logic [9:0] enc(int num);
    logic [9:0] n = 10'(num);
    return {n[4:0], n[9:5]};
  endfunction

  task automatic issue(input bit to, input logic [9:0] field, input logic [63:0] data,
                       input string req);
    exp_t e;
    logic [9:0] num;
    int k;
    @(negedge clk);
    in_valid = 1'b1; in_to_spr = to; in_field = field; in_gpr_data = data;
    num = {field[4:0], field[9:5]};
    k = idx_of(num);
    e.req = req; e.rd = 0; e.wr = 0; e.sw = 0; e.intr = 0; e.wdata = '0;
    if (k >= 0) begin
      if (to) begin e.rd = 1; e.sw = 1; model[k] = data; end
      else begin e.wr = 1; e.wdata = model[k] & mask_of(k); end
    end else if (num < 10'd808 || num > 10'd811) begin
      e.intr = 1;
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 6; i++) issue(1'b0, enc(impl_nums[i]), 64'hDEAD_0000_0000_BEEF, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (started && !done) begin
      if (res_valid) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R7: result with nothing outstanding act=1 exp=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if ({res_gpr_rd, res_gpr_wr, res_spr_wr, res_intr} != {e.rd, e.wr, e.sw, e.intr} ||
              res_gpr_wdata != e.wdata) begin
            bad++;
            $display("FAIL %s: act rd/wr/sw/intr=%b%b%b%b data=%h exp=%b%b%b%b data=%h",
                     e.req, res_gpr_rd, res_gpr_wr, res_spr_wr, res_intr, res_gpr_wdata,
                     e.rd, e.wr, e.sw, e.intr, e.wdata);
          end
        end
      end else begin
        total++;
        if (res_gpr_rd || res_gpr_wr || res_spr_wr || res_intr) begin
          bad++;
          $display("FAIL R7: idle strobes act=%b%b%b%b exp=0000",
                   res_gpr_rd, res_gpr_wr, res_spr_wr, res_intr);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    total++;
    if (res_valid !== 1'b0 || res_intr !== 1'b0) begin
      bad++;
      $display("FAIL R2: during reset act valid=%b intr=%b exp=0 0", res_valid, res_intr);
    end
    rst = 1'b0;
    started = 1;
    read_all("R2");
    idle(2);
    // R3 writes with distinct patterns, R4/R9 readback
    issue(1'b1, enc(1),   64'h0123_4567_89AB_CDEF, "R3");
    issue(1'b1, enc(8),   64'hFFFF_FFFF_FFFF_FFFF, "R3");
    issue(1'b1, enc(9),   64'hA5A5_5A5A_F0F0_0F0F, "R3");
    issue(1'b1, enc(26),  64'h8000_0000_0000_0001, "R3");
    issue(1'b1, enc(27),  64'h0000_0000_0000_0000, "R3");
    issue(1'b1, enc(815), 64'hCAFE_F00D_1234_5678, "R1");
    idle(1);
    read_all("R4");
    issue(1'b0, enc(8), '0, "R9");
    // R8 back-to-back
    issue(1'b1, enc(9), 64'h1111_2222_3333_4444, "R8");
    issue(1'b0, enc(9), '0, "R8");
    issue(1'b1, enc(8), 64'h7766_5544_3322_1100, "R8");
    issue(1'b0, enc(8), '0, "R9");
    idle(3);
    // R5 reserved range in both directions
    for (int n = 808; n <= 811; n++) begin
      issue(1'b1, enc(n), 64'hBAD0_BAD0_BAD0_BAD0, "R5");
      issue(1'b0, enc(n), '0, "R5");
    end
    read_all("R5");
    // R6 undefined neighbours and extremes
    issue(1'b1, enc(807),  64'h5555_5555_5555_5555, "R6");
    issue(1'b1, enc(812),  64'h5555_5555_5555_5555, "R6");
    issue(1'b0, enc(816),  '0, "R6");
    issue(1'b1, enc(0),    64'h5555_5555_5555_5555, "R6");
    issue(1'b0, enc(1023), '0, "R6");
    issue(1'b1, enc(2),    64'h5555_5555_5555_5555, "R6");
    // R1 fields without the swap land elsewhere and trap
    issue(1'b1, 10'd815, 64'h6666_6666_6666_6666, "R1");
    issue(1'b0, 10'd8,   '0, "R1");
    issue(1'b1, 10'd26,  64'h6666_6666_6666_6666, "R1");
    idle(1);
    read_all("R6");
    idle(4);
    // R7 nothing left outstanding
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R7: outstanding act=%0d exp=0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule